// File: doc/BRIEF.md
# Serial Key-Unlock Register Access Controller

This block sits beside a byte-wide static memory on a simple asynchronous bus made of an active-low chip enable, output enable and write enable, plus one serial data-in bit and one serial data-out bit. It also drives a chip-enable output towards the memory. While the controller is locked, every bus cycle is passed to the memory through that output. In parallel, the controller watches the write cycles for a fixed 64-bit unlock key that arrives one bit per write on the data-in line.

Once the whole key has matched, the controller takes over the bus for exactly 64 cycles. During that window it streams a bank of eight 8-bit timekeeping registers bit by bit. Write cycles load bits into the bank and read cycles present bits on the data-out line. The memory is kept deselected for the whole window, and afterwards the controller locks again. A separate parallel host port lets the surrounding calendar logic load the registers, and a flat image output exposes them.

The controller FSM has four states. `ST_LOCKED` is idle after reset or an abort. `ST_MATCH` compares key bits against the key pointer. `ST_FROZEN` is entered after a mismatch. `ST_XFER` is the 64-cycle register window. Its transitions are as follows. Any read moves `ST_LOCKED`, `ST_MATCH` or `ST_FROZEN` to `ST_MATCH` with the pointer cleared. A matching write advances the pointer, and on the last key bit it enters `ST_XFER`. A mismatching write moves `ST_MATCH` to `ST_FROZEN`. The 64th transfer cycle moves `ST_XFER` to `ST_LOCKED`. An abort request moves any state to `ST_LOCKED`.

Top module: `serial_key_unlock`

## Requirements
- R1: After system reset all eight registers read 0, the controller is locked, and `mem_ce_n` equals `bus_ce_n`.
- R2: The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, in that order, each sent least-significant bit first as 64 consecutive write cycles. A write cycle is `bus_ce_n` and `bus_we_n` both low, and it completes when either of them rises. A full match enters the transfer window.
- R3: A read cycle (`bus_ce_n` and `bus_oe_n` low, `bus_we_n` high) resets the key pointer to the first key bit at any point before unlocking, and so discards a partial match.
- R4: A write bit that differs from the expected key bit freezes matching, and all following writes are ignored until a read cycle restarts the sequence.
- R5: The transfer window is exactly 64 bus cycles, in order from register 0 bit 0 to register 7 bit 7. A write cycle stores `bus_din`, and a read cycle shows the addressed bit on `bus_dout`. After the 64th cycle the controller is locked again and needs a read plus a full key.
- R6: While locked, `mem_ce_n` follows `bus_ce_n`. During the transfer window it is held high.
- R7: A register changes from the serial side only when all eight of its bit cycles were writes. Partial or mixed bytes leave it unchanged.
- R8: A low `xfer_abort_n` aborts any transfer or key match without changing a register, unless bit 4 of register 4 is 1. In that case the input is ignored.
- R9: While `pwr_fail` is high, any transfer is aborted without register change and no unlock can happen. `mem_ce_n` is forced high when `rom_mode` is 0 and forced low when it is 1.
- R10: Bits without a function are stored and read as 0. The kept-bit masks for registers 0 to 7 are FF, 7F, 7F, BF, 37, 3F, 1F, FF.
- R11: A host write loads the masked `host_data` into register `host_idx`. `reg_image` bits [8i+7:8i] hold register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| bus_ce_n | input | 1 | Bus chip enable, active low |
| bus_oe_n | input | 1 | Bus output enable, active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_din | input | 1 | Serial data bit from the bus master |
| bus_dout | output | 1 | Serial data bit to the bus master, 0 outside the transfer window |
| mem_ce_n | output | 1 | Chip enable towards the external memory |
| xfer_abort_n | input | 1 | Active-low transfer abort |
| pwr_fail | input | 1 | Supply below threshold |
| rom_mode | input | 1 | 1 selects read-only memory behaviour on power failure |
| host_wr | input | 1 | Parallel register load strobe |
| host_idx | input | 3 | Register index for a host load |
| host_data | input | 8 | Data for a host load |
| reg_image | output | 64 | All eight registers, register i at bits [8i+7:8i] |

## Verification
The embedded properties watch the FSM on every cycle. They check that a matching bit advances the pointer, that a mismatch freezes it, that a read restarts matching, that the 64th transfer cycle relocks, and that an abort request always lands in the locked state. Further properties check that the memory enable is blocked in the window and forced correctly on power failure, and that the register bank moves only on a completed byte or a host load. Only the bench scenarios can show end-to-end effects: the key value itself, the bit order through the bank, the mismatch at every one of the 64 key positions, and that partial bytes, masked aborts and power loss leave the register contents as required.

// File: rtl/sku_pkg.sv
package sku_pkg;

    localparam int KEY_LEN  = 64;
    localparam int REG_CNT  = 8;
    localparam int REG_BITS = 8;

    typedef enum logic [1:0] {
        ST_LOCKED,
        ST_MATCH,
        ST_FROZEN,
        ST_XFER
    } ctl_state_t;

    // Expected key bit at a given position, least-significant bit of each byte first.
    function automatic logic key_bit(input logic [5:0] idx);
        logic [7:0] kb;
        unique case (idx[4:3])
            2'd0: kb = 8'hC5;
            2'd1: kb = 8'h3A;
            2'd2: kb = 8'hA3;
            default: kb = 8'h5C;
        endcase
        return kb[idx[2:0]];
    endfunction

    // Bits that carry a function in each register; all others are kept at 0.
    function automatic logic [7:0] field_mask(input logic [2:0] r);
        logic [7:0] m;
        unique case (r)
            3'd0: m = 8'hFF;
            3'd1: m = 8'h7F;
            3'd2: m = 8'h7F;
            3'd3: m = 8'hBF;
            3'd4: m = 8'h37;
            3'd5: m = 8'h3F;
            3'd6: m = 8'h1F;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sku_sync.sv
module sku_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= RST_VAL;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/sku_cycle_detect.sv
module sku_cycle_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic din,
    output logic rd_evt,
    output logic wr_evt,
    output logic wbit
);

    logic rd_act, wr_act;
    logic rd_q, wr_q, wbit_q;

    assign rd_act = ~ce_n & ~oe_n & we_n;
    assign wr_act = ~ce_n & ~we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q   <= 1'b0;
            wr_q   <= 1'b0;
            wbit_q <= 1'b0;
        end else begin
            rd_q <= rd_act;
            wr_q <= wr_act;
            if (wr_act) wbit_q <= din;
        end
    end

    // A cycle is counted when its strobe ends.
    assign rd_evt = rd_q & ~rd_act;
    assign wr_evt = wr_q & ~wr_act;
    assign wbit   = wbit_q;

    // R3
    rd_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |-> $past(~ce_n & ~oe_n & we_n));

    // R2
    wr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |-> $past(~ce_n & ~we_n));

endmodule

// File: rtl/sku_unlock_fsm.sv
module sku_unlock_fsm
    import sku_pkg::*;
#(
    parameter int XFER_LEN = KEY_LEN,
    localparam int PTR_W   = $clog2(XFER_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_evt,
    input  logic             wr_evt,
    input  logic             wbit,
    input  logic             abort_req,
    output logic             xfer_on,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(XFER_LEN - 1);

    ctl_state_t       st, st_n;
    logic [PTR_W-1:0] ptr_q, ptr_n;
    logic             key_ok;

    assign key_ok = (wbit == key_bit(6'(ptr_q)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ST_LOCKED;
            ptr_q <= '0;
        end else begin
            st    <= st_n;
            ptr_q <= ptr_n;
        end
    end

    always_comb begin
        st_n  = st;
        ptr_n = ptr_q;
        if (abort_req) begin
            st_n  = ST_LOCKED;
            ptr_n = '0;
        end else begin
            unique case (st)
                ST_LOCKED, ST_FROZEN: begin
                    if (rd_evt) begin
                        st_n  = ST_MATCH;
                        ptr_n = '0;
                    end
                end
                ST_MATCH: begin
                    if (rd_evt) begin
                        ptr_n = '0;
                    end else if (wr_evt) begin
                        if (!key_ok) begin
                            st_n = ST_FROZEN;
                        end else if (ptr_q == LAST) begin
                            st_n  = ST_XFER;
                            ptr_n = '0;
                        end else begin
                            ptr_n = ptr_q + 1'b1;
                        end
                    end
                end
                ST_XFER: begin
                    if (rd_evt || wr_evt) begin
                        if (ptr_q == LAST) begin
                            st_n  = ST_LOCKED;
                            ptr_n = '0;
                        end else begin
                            ptr_n = ptr_q + 1'b1;
                        end
                    end
                end
                default: begin
                    st_n  = ST_LOCKED;
                    ptr_n = '0;
                end
            endcase
        end
    end

    always_comb begin
        xfer_on = (st == ST_XFER);
        ptr     = ptr_q;
    end

    // R2
    key_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MATCH && wr_evt && !rd_evt && !abort_req && key_ok && ptr_q != LAST)
        |=> (st == ST_MATCH && ptr_q == $past(ptr_q) + 1'b1));

    // R3
    read_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_XFER && rd_evt && !abort_req) |=> (st == ST_MATCH && ptr_q == '0));

    // R4
    mismatch_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FROZEN && !rd_evt && !abort_req) |=> (st == ST_FROZEN));

    // R5
    relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XFER && ptr_q == LAST && (rd_evt || wr_evt) && !abort_req)
        |=> (st == ST_LOCKED));

    // R8
    abort_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort_req |=> (st == ST_LOCKED && ptr_q == '0));

endmodule

// File: rtl/sku_reg_bank.sv
module sku_reg_bank
    import sku_pkg::*;
#(
    parameter int  N_REGS  = REG_CNT,
    parameter int  W_REG   = REG_BITS,
    localparam int IDX_W   = $clog2(N_REGS),
    localparam int BIT_W   = $clog2(W_REG),
    localparam int PTR_W   = IDX_W + BIT_W,
    localparam int IMG_W   = N_REGS * W_REG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_on,
    input  logic             rd_evt,
    input  logic             wr_evt,
    input  logic             wbit,
    input  logic [PTR_W-1:0] ptr,
    input  logic             host_wr,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [W_REG-1:0] host_data,
    output logic [IMG_W-1:0] image,
    output logic             dout,
    output logic             rst_mask
);

    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(W_REG - 1);

    logic [W_REG-1:0] regs [N_REGS];
    logic [W_REG-1:0] asm_q, asm_full;
    logic             all_wr_q, all_wr_now;
    logic [BIT_W-1:0] bit_sel;
    logic [IDX_W-1:0] reg_sel;
    logic             commit;

    assign bit_sel = ptr[BIT_W-1:0];
    assign reg_sel = ptr[PTR_W-1:BIT_W];

    // True when every bit cycle of the current byte so far, this one included, is a write.
    assign all_wr_now = ((bit_sel == '0) ? 1'b1 : all_wr_q) & wr_evt;
    assign commit     = xfer_on & wr_evt & (bit_sel == LAST_BIT) & all_wr_now;

    always_comb begin
        asm_full          = asm_q;
        asm_full[bit_sel] = wbit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            asm_q    <= '0;
            all_wr_q <= 1'b0;
        end else if (xfer_on && (rd_evt || wr_evt)) begin
            all_wr_q <= all_wr_now;
            if (wr_evt) asm_q[bit_sel] <= wbit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_REGS; i++) regs[i] <= '0;
        end else if (commit) begin
            regs[reg_sel] <= asm_full & W_REG'(field_mask(3'(reg_sel)));
        end else if (host_wr) begin
            regs[host_idx] <= host_data & W_REG'(field_mask(3'(host_idx)));
        end
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_image
        assign image[g*W_REG +: W_REG] = regs[g];
    end

    assign dout     = xfer_on & regs[reg_sel][bit_sel];
    assign rst_mask = regs[4][4];

    // R7
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wr && !(xfer_on && wr_evt && bit_sel == LAST_BIT)) |=> $stable(image));

    // R10
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs[1][7] == 1'b0) && (regs[3][6] == 1'b0) && (regs[6][7:5] == 3'b000));

endmodule

// File: rtl/serial_key_unlock.sv
module serial_key_unlock
    import sku_pkg::*;
#(
    parameter int  SYNC_STAGES = 2,
    localparam int IDX_W       = $clog2(REG_CNT),
    localparam int PTR_W       = $clog2(KEY_LEN),
    localparam int IMG_W       = REG_CNT * REG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_ce_n,
    input  logic                bus_oe_n,
    input  logic                bus_we_n,
    input  logic                bus_din,
    output logic                bus_dout,
    output logic                mem_ce_n,
    input  logic                xfer_abort_n,
    input  logic                pwr_fail,
    input  logic                rom_mode,
    input  logic                host_wr,
    input  logic [IDX_W-1:0]    host_idx,
    input  logic [REG_BITS-1:0] host_data,
    output logic [IMG_W-1:0]    reg_image
);

    logic [5:0]       raw_in, syn_in;
    logic             ce_s, oe_s, we_s, din_s, abn_s, pf_s;
    logic             rd_evt, wr_evt, wbit;
    logic             xfer_on, rst_mask, abort_req;
    logic [PTR_W-1:0] ptr;

    assign raw_in = {bus_ce_n, bus_oe_n, bus_we_n, bus_din, xfer_abort_n, pwr_fail};

    sku_sync #(
        .WIDTH  (6),
        .STAGES (SYNC_STAGES),
        .RST_VAL(6'b111010)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw_in),
        .q    (syn_in)
    );

    assign {ce_s, oe_s, we_s, din_s, abn_s, pf_s} = syn_in;

    sku_cycle_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_s),
        .oe_n  (oe_s),
        .we_n  (we_s),
        .din   (din_s),
        .rd_evt(rd_evt),
        .wr_evt(wr_evt),
        .wbit  (wbit)
    );

    assign abort_req = pf_s | (~abn_s & ~rst_mask);

    sku_unlock_fsm #(
        .XFER_LEN(KEY_LEN)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_evt   (rd_evt),
        .wr_evt   (wr_evt),
        .wbit     (wbit),
        .abort_req(abort_req),
        .xfer_on  (xfer_on),
        .ptr      (ptr)
    );

    sku_reg_bank #(
        .N_REGS(REG_CNT),
        .W_REG (REG_BITS)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_on  (xfer_on),
        .rd_evt   (rd_evt),
        .wr_evt   (wr_evt),
        .wbit     (wbit),
        .ptr      (ptr),
        .host_wr  (host_wr),
        .host_idx (host_idx),
        .host_data(host_data),
        .image    (reg_image),
        .dout     (bus_dout),
        .rst_mask (rst_mask)
    );

    always_comb begin
        if (pwr_fail)     mem_ce_n = ~rom_mode;
        else if (xfer_on) mem_ce_n = 1'b1;
        else              mem_ce_n = bus_ce_n;
    end

    // R6
    xfer_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && !pwr_fail) |-> mem_ce_n);

    // R9
    pf_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !rom_mode) |-> mem_ce_n);

    // R9
    pf_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && rom_mode) |-> !mem_ce_n);

    // R5
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_on |-> !bus_dout);

endmodule

// File: tb/serial_key_unlock_test.sv
module serial_key_unlock_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1, bus_din = 1'b0;
    logic        bus_dout, mem_ce_n;
    logic        xfer_abort_n = 1'b1, pwr_fail = 1'b0, rom_mode = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_idx = '0;
    logic [7:0]  host_data = '0;
    logic [63:0] reg_image;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    serial_key_unlock uut (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
        .bus_din(bus_din), .bus_dout(bus_dout), .mem_ce_n(mem_ce_n),
        .xfer_abort_n(xfer_abort_n), .pwr_fail(pwr_fail), .rom_mode(rom_mode),
        .host_wr(host_wr), .host_idx(host_idx), .host_data(host_data),
        .reg_image(reg_image)
    );

    function automatic logic [7:0] kmask(input int r);
        logic [7:0] t [8] = '{8'hFF, 8'h7F, 8'h7F, 8'hBF, 8'h37, 8'h3F, 8'h1F, 8'hFF};
        return t[r];
    endfunction

    function automatic logic [63:0] masked(input logic [63:0] v);
        logic [63:0] o;
        for (int r = 0; r < 8; r++) o[8*r +: 8] = v[8*r +: 8] & kmask(r);
        return o;
    endfunction

    function automatic bit kbit(input int i);
        logic [7:0] kb [4] = '{8'hC5, 8'h3A, 8'hA3, 8'h5C};
        return kb[(i / 8) % 4][i % 8];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_cyc(input bit is_wr, input bit d, output bit q);
        @(negedge clk);
        bus_ce_n = 1'b0;
        if (is_wr) begin bus_we_n = 1'b0; bus_din = d; end
        else       bus_oe_n = 1'b0;
        repeat (4) @(negedge clk);
        q = bus_dout;
        bus_ce_n = 1'b1; bus_oe_n = 1'b1; bus_we_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_bit(input bit d);
        bit q;
        bus_cyc(1'b1, d, q);
    endtask

    task automatic rd_bit(output bit q);
        bus_cyc(1'b0, 1'b0, q);
    endtask

    task automatic unlock();
        bit q;
        rd_bit(q);
        for (int i = 0; i < 64; i++) wr_bit(kbit(i));
    endtask

    task automatic probe_mem(input bit exp, input string req);
        @(negedge clk);
        bus_ce_n = 1'b0;
        #1;
        chk(mem_ce_n == exp, req, 64'(mem_ce_n), 64'(exp));
        bus_ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic host_load(input logic [63:0] v);
        for (int r = 0; r < 8; r++) begin
            @(negedge clk);
            host_wr = 1'b1; host_idx = 3'(r); host_data = v[8*r +: 8];
        end
        @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] pats [4] = '{64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF,
                                  64'h0F1E_2D3C_4B5A_6978, 64'hFF00_AA55_33CC_E7E7};
        logic [63:0] snap;
        logic [63:0] got;
        bit q;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        chk(reg_image == 64'd0, "R1 image", reg_image, 64'd0);
        chk(mem_ce_n == 1'b1, "R1 idle enable", 64'(mem_ce_n), 64'd1);
        probe_mem(1'b0, "R1 pass-through");

        // R2 R5 R7 R10: full writes of several patterns
        for (int p = 0; p < 4; p++) begin
            unlock();
            probe_mem(1'b1, "R6 blocked in window");
            for (int i = 0; i < 64; i++) wr_bit(pats[p][i]);
            chk(reg_image == masked(pats[p]), "R2/R5/R10 write pattern", reg_image, masked(pats[p]));
            probe_mem(1'b0, "R5 relocked after 64");
        end

        // R11 R5 read-out of host-loaded values
        host_load(64'hA5C3_7E19_F0B4_6D28);
        chk(reg_image == masked(64'hA5C3_7E19_F0B4_6D28), "R11 host load",
            reg_image, masked(64'hA5C3_7E19_F0B4_6D28));
        unlock();
        for (int i = 0; i < 64; i++) begin
            rd_bit(q);
            got[i] = q;
        end
        chk(got == masked(64'hA5C3_7E19_F0B4_6D28), "R5 serial read order", got,
            masked(64'hA5C3_7E19_F0B4_6D28));
        probe_mem(1'b0, "R6 relocked after reads");

        // R4 mismatch at every key position
        snap = reg_image;
        for (int pos = 0; pos < 64; pos++) begin
            rd_bit(q);
            for (int i = 0; i < 64; i++) wr_bit(kbit(i) ^ (i == pos));
            wr_bit(1'b1);
            chk(mem_ce_n == 1'b1 && reg_image == snap, "R4 frozen no unlock", reg_image, snap);
            probe_mem(1'b0, "R4 still locked");
        end

        // R3 read mid-key restarts the pointer
        rd_bit(q);
        for (int i = 0; i < 30; i++) wr_bit(kbit(i));
        rd_bit(q);
        for (int i = 30; i < 64; i++) wr_bit(kbit(i));
        probe_mem(1'b0, "R3 tail alone does not unlock");
        rd_bit(q);
        for (int i = 0; i < 20; i++) wr_bit(kbit(i));
        unlock();
        probe_mem(1'b1, "R3 restart then full key unlocks");
        for (int i = 0; i < 64; i++) rd_bit(q);

        // R7 R8 partial byte then abort
        host_load(64'h1122_3344_0566_7788);
        snap = reg_image;
        unlock();
        for (int i = 0; i < 8; i++) wr_bit(8'h5A >> i);
        for (int i = 0; i < 4; i++) wr_bit(1'b1);
        @(negedge clk); xfer_abort_n = 1'b0;
        repeat (6) @(negedge clk); xfer_abort_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(reg_image[7:0] == 8'h5A, "R7 complete byte kept", 64'(reg_image[7:0]), 64'h5A);
        chk(reg_image[63:8] == snap[63:8], "R8 abort leaves rest", reg_image, snap);
        probe_mem(1'b0, "R8 abort relocks");

        // R7 mixed byte not committed
        snap = reg_image;
        unlock();
        for (int i = 0; i < 7; i++) wr_bit(1'b1);
        rd_bit(q);
        for (int i = 8; i < 64; i++) rd_bit(q);
        chk(reg_image == snap, "R7 mixed byte", reg_image, snap);

        // R8 abort ignored when mask bit set
        host_load(64'h0000_0010_0000_0000);
        unlock();
        for (int i = 0; i < 4; i++) rd_bit(q);
        @(negedge clk); xfer_abort_n = 1'b0;
        repeat (6) @(negedge clk); xfer_abort_n = 1'b1;
        repeat (6) @(negedge clk);
        probe_mem(1'b1, "R8 masked abort ignored");
        for (int i = 4; i < 64; i++) rd_bit(q);
        probe_mem(1'b0, "R8 window completed");

        // R9 power failure
        host_load(64'h0000_0000_0000_0033);
        snap = reg_image;
        unlock();
        for (int i = 0; i < 4; i++) wr_bit(1'b0);
        @(negedge clk); pwr_fail = 1'b1;
        repeat (4) @(negedge clk);
        chk(mem_ce_n == 1'b1, "R9 RAM forced high", 64'(mem_ce_n), 64'd1);
        probe_mem(1'b1, "R9 RAM forced high with ce low");
        rom_mode = 1'b1;
        #1 chk(mem_ce_n == 1'b0, "R9 ROM forced low", 64'(mem_ce_n), 64'd0);
        rom_mode = 1'b0;
        unlock();
        @(negedge clk); pwr_fail = 1'b0;
        repeat (6) @(negedge clk);
        probe_mem(1'b0, "R9 no unlock during failure");
        for (int i = 0; i < 8; i++) wr_bit(1'b1);
        chk(reg_image == snap, "R9 no register change", reg_image, snap);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule